// File: doc/BRIEF.md
# Three-Phase Complementary Dead-Time Inserter

This block turns three raw phase commands into three pairs of complementary gate drives, one high-side and one low-side output per phase. Whenever the raw command of a phase changes, the outgoing output of that pair switches off at once. The incoming output follows only after a programmable blanking gap, so the two switches of an inverter leg are never on together. This keeps the DC link from being shorted through a leg.

The gap is twice the active dead-time setting, counted in clock cycles. The setting is 10 bits wide and all three pairs share it. A setting of zero gives no gap, so the edges pass straight through. The timing unit presents a new setting on `dead_time_i`. The block adopts it only on the rising edge of the period sync strobe, so the gap cannot change in the middle of a switching half-period. Each phase has its own down-counter. Every raw transition reloads that counter, so a command that bounces inside the gap keeps both outputs off and starts the gap again.

Top module: `dti_top`

## Requirements
- R1: While `rst_ni` is low, all six gate outputs are low. The active dead-time value resets to 0.
- R2: `high_o[i]` and `low_o[i]` are never high in the same cycle, for any phase i.
- R3: Let the active setting be D>0. A change of `phase_i[i]` sampled at clock edge k drives both outputs of pair i low from edge k. At edge k+2D, the output that matches the new level turns on: `high_o[i]` for 1, `low_o[i]` for 0. Both outputs are therefore low for exactly 2D cycles.
- R4: With an active setting of 0, the outgoing output turns off and the incoming output turns on at the same clock edge: the first edge that samples the new raw level.
- R5: The active setting takes the value of `dead_time_i` only at a clock edge where `sync_i` is sampled high after being sampled low on the previous edge. At every other edge, changes on `dead_time_i` have no effect on the gap.
- R6: When a raw transition and a sync rising edge are sampled at the same clock edge, that transition is timed with the previous active setting. Later transitions use the new setting.
- R7: If `phase_i[i]` changes again before its gap has elapsed, both outputs of pair i stay low. The gap restarts from that later transition.
- R8: All three pairs use the same active setting, but each pair times its own transitions independently of the others.
- R9: The full 10-bit range is honoured: a setting of 1023 gives a gap of 2046 cycles.
- R10: At the first clock edge after reset release, each pair turns on the output that matches its raw level: `high_o[i]` if `phase_i[i]` is 1, `low_o[i]` if it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_i | input | 3 | Raw phase commands, one bit per leg |
| sync_i | input | 1 | Period sync strobe; its rising edge adopts a new setting |
| dead_time_i | input | 10 | Candidate dead-time setting, in units of two clock cycles |
| high_o | output | 3 | High-side gate drives |
| low_o | output | 3 | Low-side gate drives |

## Verification
Two events can land on the same clock edge: adopting a new dead-time setting at a sync rising edge, and a raw transition that loads a phase counter. The bench raises `sync_i` together with a new `dead_time_i` and a phase toggle in one drive step. The scoreboard's model times that toggle with the old setting and the next toggle with the new one, and every cycle's six outputs are compared against it. A second coincidence sets a toggle on the exact edge where a gap would expire. The random section provokes it, and there the restart must win over the turn-on.

// File: rtl/dti_pkg.sv
package dti_pkg;
  localparam int unsigned NUM_PHASES_DEF = 3;
  localparam int unsigned DT_W_DEF       = 10;

  typedef enum logic [1:0] {
    LEG_LOW_ON  = 2'b01,
    LEG_HIGH_ON = 2'b10,
    LEG_BLANK   = 2'b00
  } leg_state_e;

  function automatic leg_state_e leg_for_level(input logic lvl);
    return lvl ? LEG_HIGH_ON : LEG_LOW_ON;
  endfunction
endpackage

// File: rtl/dti_dt_reg.sv
module dti_dt_reg #(
  parameter int unsigned DT_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sync_i,
  input  logic [DT_W-1:0] dead_time_i,
  output logic [DT_W-1:0] dt_act_o,
  output logic            dt_zero_o
);
  logic sync_q;
  logic sync_rise;

  assign sync_rise = sync_i & ~sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= 1'b0;
      dt_act_o <= '0;
    end else begin
      sync_q <= sync_i;
      if (sync_rise) dt_act_o <= dead_time_i;
    end
  end

  assign dt_zero_o = (dt_act_o == '0);
endmodule

// File: rtl/dti_gap_timer.sv
module dti_gap_timer #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o,
  output logic             busy_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)            cnt_d = load_val_i;
    else if (cnt_q != '0)  cnt_d = cnt_q - ONE;
  end

  // reset value of one arms a turn-on at the first edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= ONE;
    else         cnt_q <= cnt_d;
  end

  assign expire_o = (cnt_q == ONE);
  assign busy_o   = (cnt_q != '0);
endmodule

// File: rtl/dti_leg.sv
module dti_leg
  import dti_pkg::*;
#(
  parameter int unsigned DT_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            raw_i,
  input  logic [DT_W-1:0] dt_act_i,
  input  logic            dt_zero_i,
  output logic            high_o,
  output logic            low_o
);
  localparam int unsigned CNT_W = DT_W + 1;

  logic             raw_q;
  logic             raw_edge;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expire;
  logic             tmr_busy;
  leg_state_e       st_q;
  leg_state_e       st_d;

  assign raw_edge = raw_i ^ raw_q;
  assign tmr_load = raw_edge;
  assign tmr_val  = dt_zero_i ? '0 : {dt_act_i, 1'b0};

  dti_gap_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expire_o   (tmr_expire),
    .busy_o     (tmr_busy)
  );

  // a transition has priority over a turn-on due at the same edge
  always_comb begin
    st_d = st_q;
    if (raw_edge) begin
      st_d = dt_zero_i ? leg_for_level(raw_i) : LEG_BLANK;
    end else if (tmr_expire) begin
      st_d = leg_for_level(raw_i);
    end else if (tmr_busy) begin
      st_d = LEG_BLANK;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= 1'b0;
      st_q  <= LEG_BLANK;
    end else begin
      raw_q <= raw_i;
      st_q  <= st_d;
    end
  end

  assign high_o = (st_q == LEG_HIGH_ON);
  assign low_o  = (st_q == LEG_LOW_ON);
endmodule

// File: rtl/dti_top.sv
module dti_top
  import dti_pkg::*;
#(
  parameter int unsigned NUM_PHASES = NUM_PHASES_DEF,
  parameter int unsigned DT_W       = DT_W_DEF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PHASES-1:0] phase_i,
  input  logic                  sync_i,
  input  logic [DT_W-1:0]       dead_time_i,
  output logic [NUM_PHASES-1:0] high_o,
  output logic [NUM_PHASES-1:0] low_o
);
  logic [DT_W-1:0] dt_act;
  logic            dt_zero;

  dti_dt_reg #(.DT_W(DT_W)) u_dt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_i      (sync_i),
    .dead_time_i (dead_time_i),
    .dt_act_o    (dt_act),
    .dt_zero_o   (dt_zero)
  );

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_leg
    dti_leg #(.DT_W(DT_W)) u_leg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .raw_i     (phase_i[g]),
      .dt_act_i  (dt_act),
      .dt_zero_i (dt_zero),
      .high_o    (high_o[g]),
      .low_o     (low_o[g])
    );
  end
endmodule

// File: rtl/dti_top_chk.sv
module dti_top_chk #(
  parameter int unsigned NUM_PHASES = 3,
  parameter int unsigned DT_W       = 10
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_PHASES-1:0] phase_i,
  input logic                  sync_i,
  input logic [NUM_PHASES-1:0] high_o,
  input logic [NUM_PHASES-1:0] low_o,
  input logic [DT_W-1:0]       dt_act
);
  logic [NUM_PHASES-1:0] ph_q;
  logic                  sy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= '0;
      sy_q <= 1'b0;
    end else begin
      ph_q <= phase_i;
      sy_q <= sync_i;
    end
  end

  // R5: setting moves only after a sampled sync rise
  a_r5_dt_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sync_i && !sy_q) |=> (dt_act == $past(dt_act)));

  for (genvar i = 0; i < NUM_PHASES; i++) begin : g_chk
    // R2
    a_r2_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(high_o[i] && low_o[i]));
    // R3: a high-side turn-on follows a sampled high level
    a_r3_high_on_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(high_o[i]) |-> $past(phase_i[i]));
    // R3: a low-side turn-on follows a sampled low level
    a_r3_low_on_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(low_o[i]) |-> !$past(phase_i[i]));
    // R7: a transition under a nonzero setting blanks the pair
    a_r7_edge_blanks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((phase_i[i] != ph_q[i]) && (dt_act != '0)) |=> (!high_o[i] && !low_o[i]));
    // R4: a zero setting passes the level straight through
    a_r4_zero_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((phase_i[i] != ph_q[i]) && (dt_act == '0)) |=> (high_o[i] == $past(phase_i[i])) && (low_o[i] == !$past(phase_i[i])));
  end
endmodule

bind dti_top dti_top_chk #(.NUM_PHASES(NUM_PHASES), .DT_W(DT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .phase_i (phase_i),
  .sync_i  (sync_i),
  .high_o  (high_o),
  .low_o   (low_o),
  .dt_act  (dt_act)
);

// File: tb/dti_top_test.sv
module dti_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;
  localparam int DW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] phase = '0;
  logic          sync = 1'b0;
  logic [DW-1:0] dead_time = '0;
  logic [NP-1:0] high, low;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic [NP-1:0] hi;
    logic [NP-1:0] lo;
    string         tag;
  } exp_t;
  exp_t sb_q[$];

  // reference state
  bit            m_prev [NP];
  bit            m_pend [NP];
  int            m_on_at[NP];
  logic [NP-1:0] m_hi, m_lo;
  int            m_dt;
  bit            m_sprev;
  int            step_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  dti_top uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .phase_i     (phase),
    .sync_i      (sync),
    .dead_time_i (dead_time),
    .high_o      (high),
    .low_o       (low)
  );

  task automatic chk(input string tag, input logic [NP-1:0] ah, input logic [NP-1:0] al,
                     input logic [NP-1:0] eh, input logic [NP-1:0] el);
    n_cmp++;
    if (ah !== eh || al !== el) begin
      n_bad++;
      $display("FAIL %s: high=%b low=%b expected high=%b low=%b", tag, ah, al, eh, el);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NP; i++) begin
      m_prev[i] = 1'b0; m_pend[i] = 1'b1; m_on_at[i] = 0;
    end
    m_hi = '0; m_lo = '0; m_dt = 0; m_sprev = 1'b0; step_n = 0;
  endtask

  // driver: apply one cycle of stimulus and queue what must follow the next edge
  task automatic step(input logic [NP-1:0] ph, input logic sy, input int dtv, input string tag);
    exp_t it;
    phase = ph; sync = sy; dead_time = DW'(dtv);
    for (int i = 0; i < NP; i++) begin
      if (ph[i] != m_prev[i]) begin
        m_prev[i] = ph[i];
        if (m_dt == 0) begin
          m_hi[i] = ph[i]; m_lo[i] = ~ph[i]; m_pend[i] = 1'b0;
        end else begin
          m_hi[i] = 1'b0; m_lo[i] = 1'b0; m_pend[i] = 1'b1;
          m_on_at[i] = step_n + 2 * m_dt;
        end
      end else if (m_pend[i] && step_n == m_on_at[i]) begin
        m_hi[i] = ph[i]; m_lo[i] = ~ph[i]; m_pend[i] = 1'b0;
      end
    end
    if (sy && !m_sprev) m_dt = dtv;
    m_sprev = sy;
    it.hi = m_hi; it.lo = m_lo; it.tag = tag;
    sb_q.push_back(it);
    step_n++;
    @(negedge clk);
  endtask

  task automatic hold(input int n, input string tag);
    for (int k = 0; k < n; k++) step(phase, 1'b0, int'(dead_time), tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        chk(it.tag, high, low, it.hi, it.lo);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    model_reset();
    phase = 3'b101;
    repeat (3) @(negedge clk);
    chk("R1 outputs low in reset", high, low, '0, '0);
    phase = 3'b000;
    @(negedge clk);
    chk("R1 outputs low in reset", high, low, '0, '0);
    rst_n = 1'b1;

    step(3'b010, 1'b0, 0, "R10");
    hold(2, "R10");
    step(3'b011, 1'b0, 0, "R4");
    step(3'b001, 1'b0, 0, "R4");
    hold(2, "R4");
    step(3'b000, 1'b0, 3, "R5");
    hold(2, "R5");
    step(3'b000, 1'b1, 3, "R5");
    step(3'b001, 1'b0, 3, "R3");
    hold(8, "R3");
    step(3'b011, 1'b0, 5, "R5");
    hold(8, "R5");
    step(3'b111, 1'b0, 5, "R7");
    hold(2, "R7");
    step(3'b011, 1'b0, 5, "R7");
    hold(3, "R7");
    step(3'b111, 1'b0, 5, "R7");
    hold(9, "R7");
    step(3'b110, 1'b1, 2, "R6");
    hold(7, "R6");
    step(3'b111, 1'b0, 2, "R6");
    hold(6, "R6");
    step(3'b000, 1'b0, 2, "R8");
    step(3'b000, 1'b0, 2, "R8");
    step(3'b001, 1'b0, 2, "R8");
    step(3'b011, 1'b0, 2, "R8");
    hold(6, "R8");
    step(3'b011, 1'b1, 1023, "R9");
    step(3'b010, 1'b0, 1023, "R9");
    hold(2050, "R9");
    step(3'b010, 1'b1, 1, "R2");
    step(3'b010, 1'b0, 1, "R2");
    lf = 16'hace1;
    for (int k = 0; k < 400; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[2:0], lf[9], int'(lf[12:11]), "R2");
    end
    hold(12, "R2");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule